// File: doc/BRIEF.md
# Byte-Aliased General Register File

This block holds four 16-bit general registers and a separate 16-bit stack pointer for a small execution datapath. Each general register can be used whole, or as two 8-bit halves that are read and written on their own. A byte half is not separate storage. It is one lane of the word register that contains it, so a byte write changes only that lane and the other half keeps its value.

There is one synchronous write port and two combinational read ports. Each port takes a size select (word or byte) and a 3-bit register code. The stack pointer has its own load strobe and data input. It also has an output that always shows its value, and it is not affected by general register traffic. Reset is asynchronous and active-low. Its release is synchronised to the clock inside the block, and reset clears every register to zero.

Top module: `byte_alias_regfile`

## Requirements
- R1: While reset is asserted, and after it is released, every general register reads zero in both word and byte size, and the stack pointer output is zero. Asserting reset in the middle of operation clears all of them at once, without waiting for a clock edge.
- R2: A write with size=0 (word) replaces all 16 bits of one register. Code bits [1:0] choose the register: 0 is the A pair, 1 is the C pair, 2 is the D pair and 3 is the B pair. Code bit 2 is ignored for word writes and word reads.
- R3: A write with size=1 (byte) and code 0–3 loads wr_data[7:0] into bits [7:0] of the register chosen by code bits [1:0]. Bits [15:8] of that register keep their value.
- R4: A byte write with code 4–7 loads wr_data[7:0] into bits [15:8] of the register chosen by code bits [1:0]. Bits [7:0] keep their value.
- R5: A byte read returns the selected half in bits [7:0] of the read port, with bits [15:8] zero. Codes 0–3 select the low halves and codes 4–7 select the high halves.
- R6: A word read of a register returns its high half in bits [15:8] and its low half in bits [7:0], so it reflects all earlier byte writes to either half.
- R7: The two read ports decode independently. Each port reflects a change of its own size or code within the same cycle, without a clock edge.
- R8: A read of the register being written in that cycle returns the old contents. The new value appears after the clock edge.
- R9: While wr_en is 0, no general register changes, whatever the other write inputs are.
- R10: When sp_load is 1, the stack pointer takes sp_data at the clock edge. Otherwise it holds its value. General register writes never change it, and stack pointer loads never change a general register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the general registers |
| wr_byte | input | 1 | Write size: 0 word, 1 byte |
| wr_code | input | 3 | Write register code |
| wr_data | input | 16 | Write data (byte writes use bits [7:0]) |
| rd0_byte | input | 1 | Read port 0 size: 0 word, 1 byte |
| rd0_code | input | 3 | Read port 0 register code |
| rd0_data | output | 16 | Read port 0 data |
| rd1_byte | input | 1 | Read port 1 size: 0 word, 1 byte |
| rd1_code | input | 3 | Read port 1 register code |
| rd1_data | output | 16 | Read port 1 data |
| sp_load | input | 1 | Stack pointer load strobe |
| sp_data | input | 16 | Stack pointer load value |
| sp_q | output | 16 | Stack pointer contents |

## Verification
The read ports have no register between their inputs and their outputs. The bench therefore checks a change of read code or size one nanosecond after driving it, with no clock edge in between. A write, whether word, byte lane or stack pointer load, is visible exactly one rising edge later, so its readback is sampled 1 ns after that edge, with the write strobe already dropped. The read-during-write case is sampled twice: once before the edge, where the old value is expected, and once after it. Reset assertion is checked 1 ns after the falling edge of rst_n. After release, the bench waits more than the two synchroniser edges before it writes anything.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  localparam int GPR_WORD_W   = 16;
  localparam int GPR_NUM_REGS = 4;

  // Access size encoding shared by write and read ports.
  typedef enum logic {
    GPR_SZ_WORD = 1'b0,
    GPR_SZ_BYTE = 1'b1
  } gpr_size_e;

endpackage

// File: rtl/gpr_rst_sync.sv
module gpr_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  // Assert at once, release after two rising edges.
  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
  parameter int NUM_REGS = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic                            wr_byte,
  input  logic [$clog2(NUM_REGS):0]       wr_code,
  output logic [NUM_REGS-1:0]             lo_we,
  output logic [NUM_REGS-1:0]             hi_we
);

  localparam int IDX_W = $clog2(NUM_REGS);

  logic [IDX_W-1:0] idx;
  logic             hi_sel;

  assign idx    = wr_code[IDX_W-1:0];
  assign hi_sel = wr_code[IDX_W];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_lane
    logic hit;
    assign hit      = wr_en && (idx == IDX_W'(g));
    assign lo_we[g] = hit && (!wr_byte || !hi_sel);
    assign hi_we[g] = hit && (!wr_byte ||  hi_sel);
  end

  // R3/R4: a byte write opens exactly one lane in the whole file.
  p_byte_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_byte) |-> ($countones({lo_we, hi_we}) == 1));

  // R9: no lane opens without the strobe.
  p_idle_no_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> ({lo_we, hi_we} == '0));

  // R2: a word write opens both lanes of one register.
  p_word_two_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_byte) |-> ($countones({lo_we, hi_we}) == 2));

endmodule

// File: rtl/gpr_word_reg.sv
module gpr_word_reg #(
  parameter int WORD_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lo_we,
  input  logic                 hi_we,
  input  logic [WORD_W/2-1:0]  lo_d,
  input  logic [WORD_W/2-1:0]  hi_d,
  output logic [WORD_W-1:0]    q
);

  localparam int HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] lo_q, hi_q;
  logic [HALF_W-1:0] lo_nxt, hi_nxt;
  logic              lo_ce, hi_ce;

  // Next state per lane.
  always_comb begin
    lo_ce  = lo_we;
    hi_ce  = hi_we;
    lo_nxt = lo_we ? lo_d : lo_q;
    hi_nxt = hi_we ? hi_d : hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_ce) begin
      lo_q <= lo_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (hi_ce) begin
      hi_q <= hi_nxt;
    end
  end

  assign q = {hi_q, lo_q};

  // R3: a low-lane-only write leaves the upper half alone.
  p_lo_keeps_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we && !hi_we) |=> (q[WORD_W-1:HALF_W] == $past(q[WORD_W-1:HALF_W])));

  // R4: a high-lane-only write leaves the lower half alone.
  p_hi_keeps_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && !lo_we) |=> (q[HALF_W-1:0] == $past(q[HALF_W-1:0])));

  // R2: a full write lands both halves on the next cycle.
  p_word_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && lo_we) |=> (q == $past({hi_d, lo_d})));

  // R9/R10: no enable, no change.
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_we && !lo_we) |=> $stable(q));

endmodule

// File: rtl/gpr_rd_port.sv
module gpr_rd_port #(
  parameter int WORD_W   = 16,
  parameter int NUM_REGS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_REGS*WORD_W-1:0]    regs_flat,
  input  logic                          rd_byte,
  input  logic [$clog2(NUM_REGS):0]     rd_code,
  output logic [WORD_W-1:0]             rd_data
);

  import gpr_pkg::*;

  localparam int HALF_W = WORD_W / 2;
  localparam int IDX_W  = $clog2(NUM_REGS);

  logic [WORD_W-1:0] word_sel;
  logic [HALF_W-1:0] half_sel;
  gpr_size_e         size;

  always_comb begin
    size     = gpr_size_e'(rd_byte);
    word_sel = regs_flat[rd_code[IDX_W-1:0]*WORD_W +: WORD_W];
    half_sel = rd_code[IDX_W] ? word_sel[WORD_W-1:HALF_W] : word_sel[HALF_W-1:0];
    case (size)
      GPR_SZ_BYTE: rd_data = {{HALF_W{1'b0}}, half_sel};
      default:     rd_data = word_sel;
    endcase
  end

  // R5: byte reads are zero-extended.
  p_zero_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_byte |-> (rd_data[WORD_W-1:HALF_W] == '0));

endmodule

// File: rtl/byte_alias_regfile.sv
module byte_alias_regfile #(
  parameter int WORD_W   = gpr_pkg::GPR_WORD_W,
  parameter int NUM_REGS = gpr_pkg::GPR_NUM_REGS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          wr_byte,
  input  logic [$clog2(NUM_REGS):0]     wr_code,
  input  logic [WORD_W-1:0]             wr_data,
  input  logic                          rd0_byte,
  input  logic [$clog2(NUM_REGS):0]     rd0_code,
  output logic [WORD_W-1:0]             rd0_data,
  input  logic                          rd1_byte,
  input  logic [$clog2(NUM_REGS):0]     rd1_code,
  output logic [WORD_W-1:0]             rd1_data,
  input  logic                          sp_load,
  input  logic [WORD_W-1:0]             sp_data,
  output logic [WORD_W-1:0]             sp_q
);

  localparam int HALF_W = WORD_W / 2;
  localparam int N_RD   = 2;
  localparam int CODE_W = $clog2(NUM_REGS) + 1;

  logic                          rst_n_core;
  logic [NUM_REGS-1:0]           lo_we, hi_we;
  logic [HALF_W-1:0]             lane_lo_d, lane_hi_d;
  logic [NUM_REGS*WORD_W-1:0]    regs_flat;

  gpr_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_core)
  );

  gpr_wr_decode #(.NUM_REGS(NUM_REGS)) u_wr_decode (
    .clk     (clk),
    .rst_n   (rst_n_core),
    .wr_en   (wr_en),
    .wr_byte (wr_byte),
    .wr_code (wr_code),
    .lo_we   (lo_we),
    .hi_we   (hi_we)
  );

  // Byte writes carry their value in the low byte for either lane.
  assign lane_lo_d = wr_data[HALF_W-1:0];
  assign lane_hi_d = wr_byte ? wr_data[HALF_W-1:0] : wr_data[WORD_W-1:HALF_W];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_gpr
    gpr_word_reg #(.WORD_W(WORD_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n_core),
      .lo_we (lo_we[g]),
      .hi_we (hi_we[g]),
      .lo_d  (lane_lo_d),
      .hi_d  (lane_hi_d),
      .q     (regs_flat[g*WORD_W +: WORD_W])
    );
  end

  // Read ports share one structure.
  logic [N_RD-1:0]             rd_byte_v;
  logic [N_RD*CODE_W-1:0]      rd_code_v;
  logic [N_RD*WORD_W-1:0]      rd_data_v;

  assign rd_byte_v = {rd1_byte, rd0_byte};
  assign rd_code_v = {rd1_code, rd0_code};

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    gpr_rd_port #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS)) u_port (
      .clk       (clk),
      .rst_n     (rst_n_core),
      .regs_flat (regs_flat),
      .rd_byte   (rd_byte_v[p]),
      .rd_code   (rd_code_v[p*CODE_W +: CODE_W]),
      .rd_data   (rd_data_v[p*WORD_W +: WORD_W])
    );
  end

  assign rd0_data = rd_data_v[0 +: WORD_W];
  assign rd1_data = rd_data_v[WORD_W +: WORD_W];

  // Stack pointer: same lane register, both lanes on one strobe.
  gpr_word_reg #(.WORD_W(WORD_W)) u_sp (
    .clk   (clk),
    .rst_n (rst_n_core),
    .lo_we (sp_load),
    .hi_we (sp_load),
    .lo_d  (sp_data[HALF_W-1:0]),
    .hi_d  (sp_data[WORD_W-1:HALF_W]),
    .q     (sp_q)
  );

  // R10: a load lands one edge later.
  p_sp_load_r10: assert property (@(posedge clk) disable iff (!rst_n_core)
    sp_load |=> (sp_q == $past(sp_data)));

  // R10: general writes without a load leave the stack pointer alone.
  p_sp_isolated_r10: assert property (@(posedge clk) disable iff (!rst_n_core)
    (wr_en && !sp_load) |=> $stable(sp_q));

  // R8: a word read of the register under write shows the old word.
  p_old_on_collide_r8: assert property (@(posedge clk) disable iff (!rst_n_core)
    (wr_en && !rd0_byte && (rd0_code[CODE_W-2:0] == wr_code[CODE_W-2:0]))
      |-> (rd0_data == regs_flat[wr_code[CODE_W-2:0]*WORD_W +: WORD_W]));

endmodule

// File: tb/byte_alias_regfile_tb.sv
module byte_alias_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_byte;
  logic [2:0]  wr_code;
  logic [15:0] wr_data;
  logic        rd0_byte, rd1_byte;
  logic [2:0]  rd0_code, rd1_code;
  logic [15:0] rd0_data, rd1_data;
  logic        sp_load;
  logic [15:0] sp_data, sp_q;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  byte_alias_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_byte(wr_byte), .wr_code(wr_code), .wr_data(wr_data),
    .rd0_byte(rd0_byte), .rd0_code(rd0_code), .rd0_data(rd0_data),
    .rd1_byte(rd1_byte), .rd1_code(rd1_code), .rd1_data(rd1_data),
    .sp_load(sp_load), .sp_data(sp_data), .sp_q(sp_q)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {we, byte, wcode, wdata, rbyte, rcode, expected, req}
  localparam int N_VEC = 16;
  localparam logic [44:0] VEC [N_VEC] = '{
    {1'b1, 1'b0, 3'd0, 16'h1234, 1'b0, 3'd0, 16'h1234, 4'd2},  // R2 A word
    {1'b1, 1'b0, 3'd5, 16'hBEEF, 1'b0, 3'd1, 16'hBEEF, 4'd2},  // R2 bit2 ignored, C
    {1'b1, 1'b0, 3'd2, 16'h0F0F, 1'b0, 3'd6, 16'h0F0F, 4'd2},  // R2 D, read code 6
    {1'b1, 1'b0, 3'd3, 16'h8001, 1'b0, 3'd3, 16'h8001, 4'd2},  // R2 B
    {1'b1, 1'b1, 3'd0, 16'hFFAB, 1'b0, 3'd0, 16'h12AB, 4'd3},  // R3 A low
    {1'b1, 1'b1, 3'd4, 16'h00CD, 1'b0, 3'd0, 16'hCDAB, 4'd4},  // R4 A high
    {1'b1, 1'b1, 3'd1, 16'h5500, 1'b0, 3'd1, 16'hBE00, 4'd3},  // R3 C low
    {1'b1, 1'b1, 3'd5, 16'h117F, 1'b0, 3'd1, 16'h7F00, 4'd4},  // R4 C high
    {1'b1, 1'b1, 3'd6, 16'h00A5, 1'b1, 3'd6, 16'h00A5, 4'd5},  // R5 D high byte
    {1'b0, 1'b0, 3'd2, 16'hFFFF, 1'b0, 3'd2, 16'hA50F, 4'd9},  // R9 idle
    {1'b1, 1'b1, 3'd3, 16'h0055, 1'b1, 3'd3, 16'h0055, 4'd5},  // R5 B low
    {1'b1, 1'b1, 3'd7, 16'h0066, 1'b1, 3'd7, 16'h0066, 4'd5},  // R5 B high
    {1'b0, 1'b1, 3'd4, 16'h0099, 1'b1, 3'd4, 16'h00CD, 4'd9},  // R9 idle byte
    {1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd3, 16'h6655, 4'd6},  // R6 B word
    {1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 3'd2, 16'h000F, 4'd5},  // R5 D low
    {1'b1, 1'b1, 3'd0, 16'h0000, 1'b0, 3'd0, 16'hCD00, 4'd6}   // R6 A word
  };

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0;
    wr_en = 1'b0; wr_byte = 1'b0; wr_code = '0; wr_data = '0;
    rd0_byte = 1'b0; rd0_code = '0; rd1_byte = 1'b0; rd1_code = '0;
    sp_load = 1'b0; sp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      rd0_byte = 1'b0; rd0_code = 3'(i);
      rd1_byte = 1'b1; rd1_code = 3'(i + 4);
      #1;
      check("R1 word", rd0_data, 16'h0000);
      check("R1 byte", rd1_data, 16'h0000);
    end
    check("R1 sp", sp_q, 16'h0000);

    // Vector walk
    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk);
      wr_en = VEC[i][44]; wr_byte = VEC[i][43];
      wr_code = VEC[i][42:40]; wr_data = VEC[i][39:24];
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      rd0_byte = VEC[i][23]; rd0_code = VEC[i][22:20];
      #1;
      check($sformatf("R%0d vec%0d", VEC[i][3:0], i), rd0_data, VEC[i][19:4]);
    end
    // State now: A=CD00 C=7F00 D=A50F B=6655

    // R7: independent, combinational ports
    @(negedge clk);
    rd0_byte = 1'b0; rd0_code = 3'd0;
    rd1_byte = 1'b1; rd1_code = 3'd5;
    #1;
    check("R7 port0", rd0_data, 16'hCD00);
    check("R7 port1", rd1_data, 16'h007F);
    rd1_byte = 1'b0; rd1_code = 3'd2;
    #1;
    check("R7 port1 recode", rd1_data, 16'hA50F);
    check("R7 port0 unaffected", rd0_data, 16'hCD00);

    // R8: read during write
    @(negedge clk);
    wr_en = 1'b1; wr_byte = 1'b0; wr_code = 3'd0; wr_data = 16'h1111;
    rd0_byte = 1'b0; rd0_code = 3'd0;
    #1;
    check("R8 old value", rd0_data, 16'hCD00);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    check("R8 new value", rd0_data, 16'h1111);

    // R10: stack pointer load, hold, isolation
    @(negedge clk);
    sp_load = 1'b1; sp_data = 16'hFFFE;
    @(posedge clk);
    #1;
    sp_load = 1'b0; sp_data = 16'h1234;
    check("R10 load", sp_q, 16'hFFFE);
    check("R10 gpr untouched", rd0_data, 16'h1111);
    @(negedge clk);
    wr_en = 1'b1; wr_byte = 1'b0; wr_code = 3'd1; wr_data = 16'h2222;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    check("R10 hold under write", sp_q, 16'hFFFE);
    rd1_byte = 1'b0; rd1_code = 3'd1;
    #1;
    check("R10 write still lands", rd1_data, 16'h2222);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async word", rd1_data, 16'h0000);
    check("R1 async sp", sp_q, 16'h0000);
    rd0_byte = 1'b0; rd0_code = 3'd2;
    #1;
    check("R1 async D", rd0_data, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule